// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the raster timing for a video output from a set of programmable lengths. Two position counters run on the pixel clock. The horizontal counter steps every cycle. The vertical counter steps once at the end of each line. Each line is split in order into four parts: sync width, gate delay, visible gate and the remainder up to the total length. Each frame is split the same way, measured in lines.

From the counter positions the block derives horizontal sync, vertical sync, composite sync, blank and a combined visible-area gate. It also produces end-of-line and end-of-frame pulses. The gate and the two pulses come straight from the counters, so a pixel buffer can be read in step with them. The four sync and blank outputs pass through two registers so that they line up with pixel data that arrives two cycles later. Each of the four has its own polarity bit. While the video enable is low, both counters are held at zero and the outputs sit at their idle levels.

Top module: `vid_timing_gen`

## Requirements
- R1: The horizontal position runs 0 to h_tot-1 and then wraps. eol_o is high for the single cycle at position h_tot-1. When h_tot is below 2, every cycle is a last pixel.
- R2: Horizontal sync is active while the horizontal position is below h_sync. The horizontal gate is open for positions p with h_sync+h_dly <= p < h_sync+h_dly+h_vis and p below h_tot.
- R3: The vertical position advances only in a cycle where eol_o is high, and wraps after line v_tot-1. eof_o is high only when eol_o is high on line v_tot-1, so there is one eof_o per frame.
- R4: Vertical sync is active for the whole of every line whose number is below v_sync. The vertical gate is open for lines l with v_sync+v_dly <= l < v_sync+v_dly+v_vis.
- R5: gate_o is the AND of the horizontal and vertical gates. It has no added delay, and it opens in h_vis*v_vis cycles per frame when the gates fit inside the totals.
- R6: Composite sync is active when horizontal sync or vertical sync is active.
- R7: Blank is active exactly when the combined gate is closed.
- R8: hsync_o, vsync_o, csync_o and blank_o show the state of the cycle two clocks earlier.
- R9: When a polarity bit is 1, the matching output is active-high. When it is 0, the output is active-low. The polarity is captured together with the raw level in the first delay register.
- R10: While en_i is low, both positions are held at 0. gate_o, eol_o and eof_o are low, the syncs are inactive and blank is active. The first cycle with en_i high is pixel 0 of line 0.
- R11: While rst_ni is low, the positions and all four delayed outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Video enable |
| h_sync_i | input | 8 | Horizontal sync width in pixels |
| h_dly_i | input | 8 | Horizontal gate delay in pixels |
| h_vis_i | input | 16 | Visible pixels per line |
| h_tot_i | input | 16 | Total pixels per line |
| v_sync_i | input | 8 | Vertical sync width in lines |
| v_dly_i | input | 8 | Vertical gate delay in lines |
| v_vis_i | input | 16 | Visible lines per frame |
| v_tot_i | input | 16 | Total lines per frame |
| pol_hs_i | input | 1 | Horizontal sync polarity (1 = active-high) |
| pol_vs_i | input | 1 | Vertical sync polarity (1 = active-high) |
| pol_cs_i | input | 1 | Composite sync polarity (1 = active-high) |
| pol_blk_i | input | 1 | Blank polarity (1 = active-high) |
| hsync_o | output | 1 | Horizontal sync, delayed by two clocks |
| vsync_o | output | 1 | Vertical sync, delayed by two clocks |
| csync_o | output | 1 | Composite sync, delayed by two clocks |
| blank_o | output | 1 | Blank, delayed by two clocks |
| gate_o | output | 1 | Combined visible-area gate, undelayed |
| eol_o | output | 1 | End-of-line pulse |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
The main function is tried with four timing sets, and each one separates a different case:
- An ordinary set with all four phases present on both axes, checked with all polarities high.
- A set with zero sync and zero delay, where the visible region reaches the line end, checked with all polarities low.
- A set whose visible length overruns the total, which shows that the gate is cut at the wrap.
- A one-pixel line, which shows that a total below 2 still advances the vertical counter every cycle.

A bench model follows every cycle and checks each output. Per-frame counts of gate cycles, line ends and frame ends confirm the phase arithmetic. Directed steps drop the enable mid-frame, flip the polarities while running, and assert reset mid-run.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_DELAY = 2'd1,
    PH_VIS   = 2'd2,
    PH_REST  = 2'd3
  } phase_e;

  localparam int LANE_HS  = 0;
  localparam int LANE_VS  = 1;
  localparam int LANE_CS  = 2;
  localparam int LANE_BLK = 3;
  localparam int LANES    = 4;
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int SW_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [SW_W-1:0]  sync_len_i,
  input  logic [SW_W-1:0]  dly_len_i,
  input  logic [CNT_W-1:0] vis_len_i,
  input  logic [CNT_W-1:0] tot_len_i,
  output logic [CNT_W-1:0] pos_o,
  output phase_e           phase_o,
  output logic             last_o
);
  localparam int SUM_W = CNT_W + 2;

  logic [CNT_W-1:0] pos_q;
  logic [SUM_W-1:0] pos_x, tot_x, b_dly, b_vis, b_rest;

  always_comb begin
    pos_x  = SUM_W'(pos_q);
    tot_x  = SUM_W'(tot_len_i);
    b_dly  = SUM_W'(sync_len_i);
    b_vis  = b_dly + SUM_W'(dly_len_i);
    b_rest = b_vis + SUM_W'(vis_len_i);
  end

  // phase boundaries are running sums, so each phase follows the previous one
  always_comb begin
    if (pos_x < b_dly)       phase_o = PH_SYNC;
    else if (pos_x < b_vis)  phase_o = PH_DELAY;
    else if (pos_x < b_rest) phase_o = PH_VIS;
    else                     phase_o = PH_REST;
  end

  // a total below 2 makes every position the last one
  assign last_o = (pos_x + SUM_W'(1)) >= tot_x;
  assign pos_o  = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (!en_i)  pos_q <= '0;
    else if (step_i) pos_q <= last_o ? '0 : pos_q + 1'b1;
  end

  a_r10_hold_while_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pos_q == '0);
  a_r1_wrap_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && step_i && last_o |=> pos_q == '0);
  a_r1_advance_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && step_i && !last_o |=> pos_q == $past(pos_q) + 1'b1);
  a_r3_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !step_i |=> $stable(pos_q));
endmodule

// File: rtl/vtg_pipe.sv
module vtg_pipe #(
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] raw_i,
  input  logic [LANES-1:0] pol_i,
  output logic [LANES-1:0] out_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else begin
        // polarity is applied on entry: a level of 1 means active-high
        sh_q[0] <= ~(raw_i[l] ^ pol_i[l]);
        for (int s = 1; s < STAGES; s++) sh_q[s] <= sh_q[s-1];
      end
    end
    assign out_o[l] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int SW_W       = 8,
  parameter int CNT_W      = 16,
  parameter int DLY_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SW_W-1:0]  h_sync_i,
  input  logic [SW_W-1:0]  h_dly_i,
  input  logic [CNT_W-1:0] h_vis_i,
  input  logic [CNT_W-1:0] h_tot_i,
  input  logic [SW_W-1:0]  v_sync_i,
  input  logic [SW_W-1:0]  v_dly_i,
  input  logic [CNT_W-1:0] v_vis_i,
  input  logic [CNT_W-1:0] v_tot_i,
  input  logic             pol_hs_i,
  input  logic             pol_vs_i,
  input  logic             pol_cs_i,
  input  logic             pol_blk_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             csync_o,
  output logic             blank_o,
  output logic             gate_o,
  output logic             eol_o,
  output logic             eof_o
);
  logic [CNT_W-1:0] h_pos, v_pos;
  phase_e           h_ph, v_ph;
  logic             h_last, v_last;
  logic             hs_raw, vs_raw;
  logic [LANES-1:0] raw, pol, dly_out;

  vtg_axis #(.SW_W(SW_W), .CNT_W(CNT_W)) u_h_axis (
    .clk_i, .rst_ni, .en_i,
    .step_i     (1'b1),
    .sync_len_i (h_sync_i),
    .dly_len_i  (h_dly_i),
    .vis_len_i  (h_vis_i),
    .tot_len_i  (h_tot_i),
    .pos_o      (h_pos),
    .phase_o    (h_ph),
    .last_o     (h_last)
  );

  vtg_axis #(.SW_W(SW_W), .CNT_W(CNT_W)) u_v_axis (
    .clk_i, .rst_ni, .en_i,
    .step_i     (h_last),
    .sync_len_i (v_sync_i),
    .dly_len_i  (v_dly_i),
    .vis_len_i  (v_vis_i),
    .tot_len_i  (v_tot_i),
    .pos_o      (v_pos),
    .phase_o    (v_ph),
    .last_o     (v_last)
  );

  assign hs_raw = en_i && (h_ph == PH_SYNC);
  assign vs_raw = en_i && (v_ph == PH_SYNC);
  assign gate_o = en_i && (h_ph == PH_VIS) && (v_ph == PH_VIS);
  assign eol_o  = en_i && h_last;
  assign eof_o  = eol_o && v_last;

  always_comb begin
    raw[LANE_HS]  = hs_raw;
    raw[LANE_VS]  = vs_raw;
    raw[LANE_CS]  = hs_raw | vs_raw;
    raw[LANE_BLK] = ~gate_o;
    pol[LANE_HS]  = pol_hs_i;
    pol[LANE_VS]  = pol_vs_i;
    pol[LANE_CS]  = pol_cs_i;
    pol[LANE_BLK] = pol_blk_i;
  end

  vtg_pipe #(.LANES(LANES), .STAGES(DLY_STAGES)) u_pipe (
    .clk_i, .rst_ni,
    .raw_i (raw),
    .pol_i (pol),
    .out_o (dly_out)
  );

  assign hsync_o = dly_out[LANE_HS];
  assign vsync_o = dly_out[LANE_VS];
  assign csync_o = dly_out[LANE_CS];
  assign blank_o = dly_out[LANE_BLK];

  // cycles since reset, saturating, so that two-cycle lookback stays inside the run
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
  end

  a_r3_eof_inside_eol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> eol_o);
  a_r10_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !gate_o && !eol_o && !eof_o);
  a_r8_blank_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DLY_STAGES == 2) && (warm_q >= 2'd2) |-> blank_o == $past(gate_o ^ pol_blk_i, 2));
  a_r6_csync_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DLY_STAGES == 2) && (warm_q >= 2'd2) |->
      csync_o == $past(~((hs_raw | vs_raw) ^ pol_cs_i), 2));
endmodule

// File: tb/vid_timing_gen_test.sv
module vid_timing_gen_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, en;
  logic [7:0]  h_sync, h_dly, v_sync, v_dly;
  logic [15:0] h_vis, h_tot, v_vis, v_tot;
  logic        p_hs, p_vs, p_cs, p_blk;
  logic        hsync, vsync, csync, blank, gate, eol, eof;

  vid_timing_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .h_sync_i(h_sync), .h_dly_i(h_dly), .h_vis_i(h_vis), .h_tot_i(h_tot),
    .v_sync_i(v_sync), .v_dly_i(v_dly), .v_vis_i(v_vis), .v_tot_i(v_tot),
    .pol_hs_i(p_hs), .pol_vs_i(p_vs), .pol_cs_i(p_cs), .pol_blk_i(p_blk),
    .hsync_o(hsync), .vsync_o(vsync), .csync_o(csync), .blank_o(blank),
    .gate_o(gate), .eol_o(eol), .eof_o(eof)
  );

  int checks = 0, errors = 0;
  int mh = 0, mv = 0;
  logic [3:0] hq1 = '0, hq2 = '0;
  int gate_cnt, eol_cnt, eof_cnt;

  // columns: hsync hdly hvis htot vsync vdly vvis vtot pol{hs,vs,cs,blk} gates-per-frame
  localparam int NCFG = 4;
  localparam int CFG [NCFG][10] = '{
    '{2, 1, 4, 10, 1, 1, 3, 7, 15, 12},
    '{0, 0, 5,  5, 0, 2, 2, 5,  0, 10},
    '{3, 2, 8,  6, 2, 0, 1, 4, 10,  1},
    '{0, 0, 1,  1, 1, 0, 2, 3,  5,  2}
  };

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic lvl(logic raw, logic pol);
    return ~(raw ^ pol);
  endfunction

  // one cycle: inputs already driven at this negedge
  task automatic tick();
    logic hl, vl, hs, vs, g;
    logic [3:0] cur;
    #1;
    hl = (mh + 1) >= int'(h_tot);
    vl = (mv + 1) >= int'(v_tot);
    hs = en && (mh < int'(h_sync));
    vs = en && (mv < int'(v_sync));
    g  = en && (mh >= int'(h_sync) + int'(h_dly)) && (mh < int'(h_sync) + int'(h_dly) + int'(h_vis))
            && (mv >= int'(v_sync) + int'(v_dly)) && (mv < int'(v_sync) + int'(v_dly) + int'(v_vis));
    chk("R5 gate", gate, g);
    chk("R1 eol", eol, en && hl);
    chk("R3 eof", eof, en && hl && vl);
    chk("R2/R8/R9 hsync", hsync, hq2[3]);
    chk("R4/R8/R9 vsync", vsync, hq2[2]);
    chk("R6/R8 csync", csync, hq2[1]);
    chk("R7/R8 blank", blank, hq2[0]);
    gate_cnt += int'(gate);
    eol_cnt  += int'(eol);
    eof_cnt  += int'(eof);
    cur = {lvl(hs, p_hs), lvl(vs, p_vs), lvl(hs | vs, p_cs), lvl(!g, p_blk)};
    hq2 = hq1;
    hq1 = cur;
    if (!en) begin
      mh = 0; mv = 0;
    end else if (hl) begin
      mh = 0;
      mv = vl ? 0 : mv + 1;
    end else mh++;
    @(negedge clk);
  endtask

  task automatic load(int i);
    h_sync = 8'(CFG[i][0]); h_dly = 8'(CFG[i][1]); h_vis = 16'(CFG[i][2]); h_tot = 16'(CFG[i][3]);
    v_sync = 8'(CFG[i][4]); v_dly = 8'(CFG[i][5]); v_vis = 16'(CFG[i][6]); v_tot = 16'(CFG[i][7]);
    {p_hs, p_vs, p_cs, p_blk} = 4'(CFG[i][8]);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0;
    load(0);
    @(negedge clk); @(negedge clk);
    // R11 reset state
    chk("R11 hsync", hsync, 1'b0);
    chk("R11 vsync", vsync, 1'b0);
    chk("R11 csync", csync, 1'b0);
    chk("R11 blank", blank, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NCFG; i++) begin
      int ht, vt;
      load(i);
      en = 1'b0;
      repeat (3) tick();
      ht = (CFG[i][3] < 1) ? 1 : CFG[i][3];
      vt = (CFG[i][7] < 1) ? 1 : CFG[i][7];
      en = 1'b1;
      gate_cnt = 0; eol_cnt = 0; eof_cnt = 0;
      repeat (ht * vt) tick();
      chk_int("R5 gates per frame", gate_cnt, CFG[i][9]);
      chk_int("R3 lines per frame", eol_cnt, vt);
      chk_int("R3 eof per frame", eof_cnt, 1);
      repeat (ht * vt) tick();
      chk_int("R3 eof over two frames", eof_cnt, 2);
    end

    // R10: disable mid-frame, outputs go idle after the pipeline
    load(0);
    repeat (13) tick();
    en = 1'b0;
    repeat (3) tick();
    chk("R10 gate off", gate, 1'b0);
    chk("R10 hsync idle", hsync, 1'b0);
    chk("R10 vsync idle", vsync, 1'b0);
    chk("R10 blank active", blank, 1'b1);
    en = 1'b1;
    repeat (25) tick();
    // R9: polarity flip while running
    {p_hs, p_vs, p_cs, p_blk} = 4'b0000;
    repeat (80) tick();

    // R11: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R11 async hsync", hsync, 1'b0);
    chk("R11 async blank", blank, 1'b0);
    chk("R11 async csync", csync, 1'b0);
    en = 1'b0;
    @(negedge clk);
    mh = 0; mv = 0; hq1 = '0; hq2 = '0;
    rst_n = 1'b1;
    en = 1'b1;
    repeat (30) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule